// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Trigger Control

This block holds the byte queues that sit between a serial line engine and a host. It has one receive queue, filled by the line side and drained by the host, and one transmit queue, filled by the host and drained by the line side. An 8-bit control word written by the host sets how the pair behaves. That word switches the queues between 64-entry depth and single-byte holding mode, empties either queue, turns on DMA request signalling and picks a trigger code for each direction. Two write guards apply. The depth and DMA bits change only while the baud divisor is zero. The transmit trigger code changes only while the enhanced-feature input is high.

Each direction has its own trigger threshold, worked out from three sources: the 2-bit code in the control word, a 4-bit coarse value and a fine-granularity select. There are three ways to form it. A fixed four-entry table is used, and it differs between receive and transmit. A non-zero coarse value times four is used. Or, in fine mode, the coarse value and the code are joined into a 6-bit count. The receive request is high while occupancy is at or above its threshold. The transmit request is high while free space is at or above its threshold. In DMA mode, copies of the two requests drive a 2-bit DMA request bus.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset both levels are 0, the overrun flag is 0, the receive request is 0, the transmit request is 1, dma_req is 0, and the control state is all zero (single-byte mode, DMA off, both codes 0).
- R2: With the enable bit (control bit 0) at 1, each queue accepts up to 64 bytes. With it at 0, each queue holds one byte. A push into a full queue is dropped, and the stored data is kept.
- R3: Bytes leave a queue in the order they were pushed. A pop on an empty queue leaves the data output and the level unchanged.
- R4: A push into a full receive queue sets rx_overrun, and the flag stays set. Only emptying the receive queue (a clear or a change of the enable bit) resets it.
- R5: A control write with bit 2 set empties the receive queue. A control write with bit 3 set empties the transmit queue. Each clear acts once at that write and leaves the other queue untouched, and a later write with the bit at 0 clears nothing.
- R6: The enable bit (bit 0) and the DMA bit (bit 1) take a written value only when divisor_zero is 1. A write that changes the enable bit empties both queues.
- R7: The transmit code (bits 7:6) takes a written value only when ext_feat_en is 1. The receive code (bits 5:4) takes every write.
- R8: With receive fine mode off and rx_coarse at 0, the receive threshold is 8, 16, 56 or 60 for code 0, 1, 2 or 3.
- R9: With transmit fine mode off and tx_coarse at 0, the transmit threshold is 8, 16, 32 or 56 for code 0, 1, 2 or 3.
- R10: With fine mode off and a non-zero coarse value, the threshold is four times the coarse value and the 2-bit code has no effect.
- R11: With fine mode on, the threshold is the 6-bit value with the coarse field as bits 5:2 and the code as bits 1:0.
- R12: rx_req is high while the receive level is at or above the receive threshold. tx_req is high while the transmit free space is at or above the transmit threshold. In single-byte mode both thresholds are 1.
- R13: With the DMA bit at 0, dma_req is 0. With it at 1, dma_req[0] follows tx_req and dma_req[1] follows rx_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word value |
| divisor_zero | input | 1 | Baud divisor is zero (baud clock stopped) |
| ext_feat_en | input | 1 | Enhanced-feature enable, allows transmit code writes |
| rx_coarse | input | 4 | Receive coarse trigger value |
| tx_coarse | input | 4 | Transmit coarse trigger value |
| rx_fine | input | 1 | Receive fine-granularity select |
| tx_fine | input | 1 | Transmit fine-granularity select |
| rx_push | input | 1 | Write a byte into the receive queue |
| rx_din | input | 8 | Receive byte in |
| rx_pop | input | 1 | Read a byte from the receive queue |
| rx_dout | output | 8 | Last byte read from the receive queue |
| rx_level | output | 7 | Receive queue occupancy |
| rx_overrun | output | 1 | Sticky receive overrun flag |
| tx_push | input | 1 | Write a byte into the transmit queue |
| tx_din | input | 8 | Transmit byte in |
| tx_pop | input | 1 | Read a byte from the transmit queue |
| tx_dout | output | 8 | Last byte read from the transmit queue |
| tx_level | output | 7 | Transmit queue occupancy |
| rx_req | output | 1 | Receive trigger request |
| tx_req | output | 1 | Transmit trigger request |
| dma_req | output | 2 | DMA requests: bit 0 transmit, bit 1 receive |

## Verification
The threshold selector is tested with one vector table. Each vector sets a direction, fine select, coarse value and code, and then the bench fills a queue one byte at a time and records the level where the request changes. The vectors hold all four table codes for each direction, which would catch swapped RX/TX tables. They hold non-zero coarse values with a code that must be ignored, which would catch a code leaking through in coarse mode. They hold fine values at both ends of the 6-bit range, which would catch a wrong shift or a dropped bit. Directed sequences then cover single-byte mode, the write guards, the one-shot clears, overrun and DMA routing. Each of these is set up so that a wrongly accepted write or a clear that hits both queues gives a different level or request at the ports.

// File: rtl/ufp_pkg.sv
package ufp_pkg;
   // control word bit positions
   localparam int CTL_EN      = 0;
   localparam int CTL_DMA     = 1;
   localparam int CTL_RXCLR   = 2;
   localparam int CTL_TXCLR   = 3;
   localparam int CTL_RXC_LSB = 4;
   localparam int CTL_TXC_LSB = 6;
   localparam int CTL_W       = 8;
   localparam int CODE_W      = 2;
   localparam int COARSE_W    = 4;
   localparam int THR_W       = COARSE_W + CODE_W;

   typedef struct packed {
      logic              en;
      logic              dma;
      logic [CODE_W-1:0] rx_code;
      logic [CODE_W-1:0] tx_code;
   } ctl_state_t;
endpackage

// File: rtl/ufp_ctrl.sv
module ufp_ctrl
   import ufp_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             div_zero,
   input  logic             feat_en,
   output ctl_state_t       st,
   output logic             rx_flush,
   output logic             tx_flush
);
   ctl_state_t st_q;
   logic       en_chg;

   always_comb en_chg = ctl_we && div_zero && (ctl_wdata[CTL_EN] != st_q.en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else if (ctl_we) begin
         st_q.rx_code <= ctl_wdata[CTL_RXC_LSB +: CODE_W];
         if (div_zero) begin
            st_q.en  <= ctl_wdata[CTL_EN];
            st_q.dma <= ctl_wdata[CTL_DMA];
         end
         if (feat_en) st_q.tx_code <= ctl_wdata[CTL_TXC_LSB +: CODE_W];
      end
   end

   // clear bits act as one-shot strobes; nothing holds them
   assign rx_flush = (ctl_we && ctl_wdata[CTL_RXCLR]) || en_chg;
   assign tx_flush = (ctl_we && ctl_wdata[CTL_TXCLR]) || en_chg;
   assign st       = st_q;

   // R6
   en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_we && div_zero) |=> $stable(st_q.en) && $stable(st_q.dma));
   // R7
   tx_code_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_we && feat_en) |=> $stable(st_q.tx_code));
endmodule

// File: rtl/ufp_thresh.sv
module ufp_thresh
   import ufp_pkg::*;
#(
   parameter bit IS_RX = 1'b1
) (
   input  logic                en,
   input  logic                fine,
   input  logic [COARSE_W-1:0] coarse,
   input  logic [CODE_W-1:0]   code,
   output logic [THR_W-1:0]    thr
);
   logic [THR_W-1:0] tab;

   generate
      if (IS_RX) begin : g_rx_tab
         always_comb begin
            case (code)
               2'd0:    tab = THR_W'(8);
               2'd1:    tab = THR_W'(16);
               2'd2:    tab = THR_W'(56);
               default: tab = THR_W'(60);
            endcase
         end
      end else begin : g_tx_tab
         always_comb begin
            case (code)
               2'd0:    tab = THR_W'(8);
               2'd1:    tab = THR_W'(16);
               2'd2:    tab = THR_W'(32);
               default: tab = THR_W'(56);
            endcase
         end
      end
   endgenerate

   always_comb begin
      if (!en)                       thr = THR_W'(1);
      else if (fine)                 thr = {coarse, code};
      else if (coarse != '0)         thr = {coarse, {CODE_W{1'b0}}};
      else                           thr = tab;
   end
endmodule

// File: rtl/ufp_fifo.sv
module ufp_fifo #(
   parameter int DEPTH     = 64,
   parameter int WIDTH     = 8,
   parameter bit TRACK_OVR = 1'b1,
   localparam int AW = $clog2(DEPTH),
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [LW-1:0]    level,
   output logic             overrun
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp;
   logic [LW-1:0]    cnt, cap;
   logic [WIDTH-1:0] dq;
   logic             do_pop, do_push;

   always_comb begin
      cap     = en ? LW'(DEPTH) : LW'(1);
      do_pop  = pop && (cnt != '0);
      do_push = push && ((cnt < cap) || do_pop);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
         dq  <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(1);
         if (do_pop) begin
            rp <= rp + AW'(1);
            dq <= mem[rp];
         end
         cnt <= cnt + LW'(do_push) - LW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= din;
   end

   generate
      if (TRACK_OVR) begin : g_ovr
         logic ovr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  ovr_q <= 1'b0;
            else if (flush)              ovr_q <= 1'b0;
            else if (push && !do_push)   ovr_q <= 1'b1;
         end
         assign overrun = ovr_q;
      end else begin : g_no_ovr
         assign overrun = 1'b0;
      end
   endgenerate

   assign dout  = dq;
   assign level = cnt;

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= (en ? LW'(DEPTH) : LW'(1)) || $past(flush) || $changed(en));
   // R5
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> cnt == '0);
   // R3
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop && cnt == '0 && !push && !flush |=> cnt == '0 && $stable(dq));
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
   import ufp_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int WIDTH = 8,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctl_we,
   input  logic [CTL_W-1:0]    ctl_wdata,
   input  logic                divisor_zero,
   input  logic                ext_feat_en,
   input  logic [COARSE_W-1:0] rx_coarse,
   input  logic [COARSE_W-1:0] tx_coarse,
   input  logic                rx_fine,
   input  logic                tx_fine,
   input  logic                rx_push,
   input  logic [WIDTH-1:0]    rx_din,
   input  logic                rx_pop,
   output logic [WIDTH-1:0]    rx_dout,
   output logic [LW-1:0]       rx_level,
   output logic                rx_overrun,
   input  logic                tx_push,
   input  logic [WIDTH-1:0]    tx_din,
   input  logic                tx_pop,
   output logic [WIDTH-1:0]    tx_dout,
   output logic [LW-1:0]       tx_level,
   output logic                rx_req,
   output logic                tx_req,
   output logic [1:0]          dma_req
);
   generate
      if (DEPTH < (1 << THR_W) || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two and cover every threshold");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("WIDTH must be at least one");
      end
   endgenerate

   ctl_state_t       st;
   logic             rx_flush, tx_flush, tx_ovr_unused;
   logic [THR_W-1:0] rx_thr, tx_thr;
   logic [LW-1:0]    tx_cap, tx_free;

   ufp_ctrl u_ctrl (
      .clk, .rst_n, .ctl_we, .ctl_wdata,
      .div_zero (divisor_zero),
      .feat_en  (ext_feat_en),
      .st, .rx_flush, .tx_flush
   );

   ufp_thresh #(.IS_RX(1'b1)) u_rx_thr (
      .en(st.en), .fine(rx_fine), .coarse(rx_coarse), .code(st.rx_code), .thr(rx_thr)
   );
   ufp_thresh #(.IS_RX(1'b0)) u_tx_thr (
      .en(st.en), .fine(tx_fine), .coarse(tx_coarse), .code(st.tx_code), .thr(tx_thr)
   );

   ufp_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .TRACK_OVR(1'b1)) u_rx_q (
      .clk, .rst_n, .en(st.en), .flush(rx_flush), .push(rx_push), .din(rx_din),
      .pop(rx_pop), .dout(rx_dout), .level(rx_level), .overrun(rx_overrun)
   );
   ufp_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .TRACK_OVR(1'b0)) u_tx_q (
      .clk, .rst_n, .en(st.en), .flush(tx_flush), .push(tx_push), .din(tx_din),
      .pop(tx_pop), .dout(tx_dout), .level(tx_level), .overrun(tx_ovr_unused)
   );

   always_comb begin
      tx_cap  = st.en ? LW'(DEPTH) : LW'(1);
      tx_free = tx_cap - tx_level;
      rx_req  = rx_level >= LW'(rx_thr);
      tx_req  = tx_free >= LW'(tx_thr);
      dma_req = st.dma ? {rx_req, tx_req} : 2'b00;
   end

   // R13
   dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st.dma |-> dma_req == 2'b00);
   // R12
   rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_fine || rx_coarse != '0) && rx_level == '0 |-> !rx_req);
   // R4
   tx_no_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_ovr_unused);
endmodule

// File: tb/uart_fifo_pair_tb_top.sv
module uart_fifo_pair_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [7:0] ctl_wdata = '0;
   logic       divisor_zero = 1'b0, ext_feat_en = 1'b0;
   logic [3:0] rx_coarse = '0, tx_coarse = '0;
   logic       rx_fine = 1'b0, tx_fine = 1'b0;
   logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
   logic [7:0] rx_din = '0, tx_din = '0, rx_dout, tx_dout;
   logic [6:0] rx_level, tx_level;
   logic       rx_overrun, rx_req, tx_req;
   logic [1:0] dma_req;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   uart_fifo_pair dut_i (
      .clk, .rst_n, .ctl_we, .ctl_wdata, .divisor_zero, .ext_feat_en,
      .rx_coarse, .tx_coarse, .rx_fine, .tx_fine,
      .rx_push, .rx_din, .rx_pop, .rx_dout, .rx_level, .rx_overrun,
      .tx_push, .tx_din, .tx_pop, .tx_dout, .tx_level,
      .rx_req, .tx_req, .dma_req
   );

   // {is_rx, fine, coarse[3:0], code[1:0], expected_threshold[6:0]}
   localparam logic [14:0] VEC [12] = '{
      {1'b1, 1'b0, 4'd0,  2'd0, 7'd8},
      {1'b1, 1'b0, 4'd0,  2'd1, 7'd16},
      {1'b1, 1'b0, 4'd0,  2'd2, 7'd56},
      {1'b1, 1'b0, 4'd0,  2'd3, 7'd60},
      {1'b0, 1'b0, 4'd0,  2'd0, 7'd8},
      {1'b0, 1'b0, 4'd0,  2'd1, 7'd16},
      {1'b0, 1'b0, 4'd0,  2'd2, 7'd32},
      {1'b0, 1'b0, 4'd0,  2'd3, 7'd56},
      {1'b1, 1'b0, 4'd5,  2'd3, 7'd20},
      {1'b0, 1'b0, 4'd3,  2'd2, 7'd12},
      {1'b1, 1'b1, 4'd0,  2'd1, 7'd1},
      {1'b0, 1'b1, 4'd15, 2'd3, 7'd63}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic ctl_wr(input logic [7:0] d);
      @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
      @(negedge clk); ctl_we = 1'b0;
   endtask

   task automatic push_rx(input logic [7:0] b);
      @(negedge clk); rx_push = 1'b1; rx_din = b;
      @(negedge clk); rx_push = 1'b0;
   endtask

   task automatic push_tx(input logic [7:0] b);
      @(negedge clk); tx_push = 1'b1; tx_din = b;
      @(negedge clk); tx_push = 1'b0;
   endtask

   task automatic pop_rx();
      @(negedge clk); rx_pop = 1'b1;
      @(negedge clk); rx_pop = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [14:0] v;
      int          meas;
      string       tag;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rx_level", rx_level, 0);
      chk("R1 tx_level", tx_level, 0);
      chk("R1 rx_overrun", rx_overrun, 0);
      chk("R1 rx_req", rx_req, 0);
      chk("R1 tx_req", tx_req, 1);
      chk("R1 dma_req", dma_req, 0);

      // threshold vectors: R8 R9 R10 R11 R12
      divisor_zero = 1'b1; ext_feat_en = 1'b1;
      for (int i = 0; i < 12; i++) begin
         v = VEC[i];
         @(negedge clk);
         rx_fine = v[13]; tx_fine = v[13]; rx_coarse = v[12:9]; tx_coarse = v[12:9];
         if (v[14]) ctl_wr({2'b00, v[8:7], 4'b1101});
         else       ctl_wr({v[8:7], 2'b00, 4'b1101});
         meas = 0;
         for (int k = 1; k <= 64; k++) begin
            if (v[14]) begin
               push_rx(8'(k));
               if (rx_req && meas == 0) meas = k;
            end else begin
               push_tx(8'(k));
               if (!tx_req && meas == 0) meas = 65 - k;
            end
         end
         if (v[13])              tag = "R11 fine threshold";
         else if (v[12:9] != 0)  tag = "R10 coarse x4 threshold";
         else if (v[14])         tag = "R8 rx table threshold";
         else                    tag = "R9 tx table threshold";
         chk(tag, meas, int'(v[6:0]));
      end

      @(negedge clk);
      rx_fine = 1'b0; tx_fine = 1'b0; rx_coarse = '0; tx_coarse = '0;
      // single-byte mode: R2 R4 R12
      ctl_wr(8'h0C);
      push_rx(8'h11); push_rx(8'h22);
      chk("R2 rx single level", rx_level, 1);
      chk("R4 rx overrun single", rx_overrun, 1);
      chk("R12 rx_req single", rx_req, 1);
      push_tx(8'h33);
      chk("R12 tx_req single", tx_req, 0);
      push_tx(8'h44);
      chk("R2 tx single level", tx_level, 1);
      pop_rx();
      chk("R2 first byte kept", rx_dout, 8'h11);

      // enable gating: R6
      divisor_zero = 1'b0;
      ctl_wr(8'h01);
      push_rx(8'h55); push_rx(8'h66);
      chk("R6 enable blocked", rx_level, 1);
      divisor_zero = 1'b1;
      ctl_wr(8'h01);
      chk("R6 enable change empties rx", rx_level, 0);
      chk("R6 enable change empties tx", tx_level, 0);
      chk("R4 overrun cleared", rx_overrun, 0);
      push_rx(8'h01); push_rx(8'h02); push_rx(8'h03);
      chk("R2 enabled holds more", rx_level, 3);

      // order and empty pop: R3
      ctl_wr(8'h05);
      push_rx(8'hA1); push_rx(8'hB2); push_rx(8'hC3);
      pop_rx(); chk("R3 order 1", rx_dout, 8'hA1);
      pop_rx(); chk("R3 order 2", rx_dout, 8'hB2);
      pop_rx(); chk("R3 order 3", rx_dout, 8'hC3);
      pop_rx();
      chk("R3 empty pop data", rx_dout, 8'hC3);
      chk("R3 empty pop level", rx_level, 0);

      // one-shot clears: R5
      for (int k = 0; k < 5; k++) push_rx(8'(k));
      for (int k = 0; k < 4; k++) push_tx(8'(k));
      ctl_wr(8'h05);
      chk("R5 rx cleared", rx_level, 0);
      chk("R5 tx untouched", tx_level, 4);
      ctl_wr(8'h01);
      push_rx(8'h77);
      chk("R5 clear not sticky", rx_level, 1);
      chk("R5 tx still untouched", tx_level, 4);

      // overrun at full depth: R4 R2
      ctl_wr(8'h0D);
      for (int k = 0; k < 65; k++) push_rx(8'(k));
      chk("R2 full depth", rx_level, 64);
      chk("R4 overrun full", rx_overrun, 1);
      ctl_wr(8'h05);
      chk("R4 overrun clear", rx_overrun, 0);

      // transmit code gating: R7
      ext_feat_en = 1'b1;
      ctl_wr(8'h09);
      for (int k = 0; k < 40; k++) push_tx(8'(k));
      chk("R7 tx_req thr 8", tx_req, 1);
      ext_feat_en = 1'b0;
      ctl_wr(8'hC1);
      chk("R7 tx code blocked", tx_req, 1);
      ext_feat_en = 1'b1;
      ctl_wr(8'hC1);
      chk("R7 tx code taken", tx_req, 0);
      ext_feat_en = 1'b0;
      ctl_wr(8'hF1);
      for (int k = 0; k < 8; k++) push_rx(8'(k));
      chk("R7 rx code always taken", rx_req, 0);

      // DMA routing: R13 R6
      ext_feat_en = 1'b1;
      ctl_wr(8'h09);
      chk("R13 dma off", dma_req, 0);
      divisor_zero = 1'b0;
      ctl_wr(8'h0B);
      chk("R6 dma bit blocked", dma_req, 0);
      divisor_zero = 1'b1;
      ctl_wr(8'h03);
      chk("R13 dma both", dma_req, 3);
      pop_rx();
      chk("R13 dma tx only", dma_req, 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule